// File: doc/BRIEF.md
# Serial Configuration Sequencer

This block loads a configuration image into a programmable device through its slave-serial port. It drives three lines toward the target: a program strobe, a configuration clock and a serial data line. It watches two status lines that come back from the target: an initialisation flag and a completion flag. A one-cycle start pulse opens a session. The block first asserts the program strobe and waits for the target to pull its initialisation flag low. It then releases the strobe and waits for the flag to return high. Next it takes configuration words from an upstream source over a valid/ready handshake and sends them out bit by bit. Last, it waits for the completion flag.

Each of the three waits is checked at a fixed poll interval. The interval is a number of core clock cycles set by a parameter, so a 1 ms interval on silicon can shrink to a few cycles in simulation. If one wait runs out, the session ends with an error code that names that phase. A single-cycle result strobe reports the outcome. The two status inputs cross into the core clock domain through synchronizer chains.

Top module: `cfgseq_loader`

## Requirements
- R1: After reset and between sessions, `cclk_o` and `cdata_o` are high, `prog_o` is at its inactive level, and `busy_o` and `s_ready_o` are low.
- R2: A start pulse asserts the program strobe. The synchronized init flag is polled once every TICK_DIV cycles. The first poll that sees it low moves the block on, and up to POLL_LIMIT+1 polls are made. If every poll sees it high, the result is -1 (3'b111) and all lines return to their idle levels.
- R3: After init is seen low, the program strobe is released and init is polled the same way until it is seen high. If it never is, the result is -2 (3'b110).
- R4: Each bit goes out in four steps of PHASE_CYC cycles each: clock low with data high, then data set to the bit, then clock high, then data back high. The clock therefore stays low for 2*PHASE_CYC cycles, data is stable when the clock rises, and data is high when the clock falls.
- R5: Each accepted word of WORD_W bits is sent most significant bit first. The word that is accepted with `s_last_i` high is the final word of the session.
- R6: After the final bit, the synchronized done flag is polled the same way. If it is seen high, the result is 0 (3'b000). Otherwise the result is -3 (3'b101).
- R7: `res_valid_o` is high for exactly one cycle per session, in the cycle where `busy_o` drops. `res_code_o` holds one of the four codes above.
- R8: `s_ready_o` is high only during the shifting phase. A word offered at any other time (idle, or during a handshake that ends in an error) is never accepted and never produces a clock edge.
- R9: A start pulse while a session is running is ignored. The session completes with its own bits and produces exactly one result.
- R10: With PROG_ACT_HIGH set, the program strobe idles low and is asserted high. By default it idles high and is asserted low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse |
| busy_o | output | 1 | A session is in progress |
| s_valid_i | input | 1 | Upstream word valid |
| s_ready_o | output | 1 | Block takes a word this cycle |
| s_data_i | input | WORD_W | Upstream configuration word |
| s_last_i | input | 1 | Marks the final word of the image |
| prog_o | output | 1 | Program strobe toward the target |
| cclk_o | output | 1 | Configuration clock toward the target |
| cdata_o | output | 1 | Serial configuration data toward the target |
| init_i | input | 1 | Target initialisation flag (asynchronous) |
| done_i | input | 1 | Target completion flag (asynchronous) |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_code_o | output | 3 | Result: 0 success, -1/-2/-3 phase timeouts (two's complement) |

## Verification
The hardest case to reach is the poll boundary. The status flag changes only after enough polls have gone by that the last permitted poll is the one that sees it, and one poll later the session would have failed. The bench models the target with per-phase delays counted from the program strobe edges. One session places the init fall between the fourth and fifth polls. Other sessions never answer a given phase, so each error code is reached. Words are offered during a failing handshake to show that they are never shifted.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_REL,
      ST_SHIFT,
      ST_DONEW
   } cfg_state_e;

   typedef enum logic [1:0] {
      SP_CLK_LO,
      SP_DATA,
      SP_CLK_HI,
      SP_RESTORE
   } bit_step_e;

   typedef logic [2:0] res_code_t;

   localparam res_code_t RC_OK        = 3'b000;
   localparam res_code_t RC_INIT_LOW  = 3'b111;
   localparam res_code_t RC_INIT_HIGH = 3'b110;
   localparam res_code_t RC_DONE      = 3'b101;

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgseq_watch.sv
module cfgseq_watch #(
   parameter int TICK_DIV   = 100000,
   parameter int POLL_LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic cond_i,
   output logic met_o,
   output logic expired_o
);

   localparam int DIV_W  = $clog2(TICK_DIV);
   localparam int POLL_W = $clog2(POLL_LIMIT + 1);

   if (TICK_DIV < 2) begin : g_bad_div
      $error("cfgseq_watch: TICK_DIV must be at least 2");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("cfgseq_watch: POLL_LIMIT must be at least 1");
   end

   logic [DIV_W-1:0]  div_q;
   logic [POLL_W-1:0] poll_q;
   logic              tick;

   assign tick      = arm_i && (div_q == DIV_W'(TICK_DIV - 1));
   assign met_o     = tick && cond_i;
   assign expired_o = tick && !cond_i && (poll_q == POLL_W'(POLL_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         poll_q <= '0;
      end else if (!arm_i || met_o || expired_o) begin
         div_q  <= '0;
         poll_q <= '0;
      end else if (tick) begin
         div_q  <= '0;
         poll_q <= poll_q + POLL_W'(1);
      end else begin
         div_q  <= div_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/cfgseq_shift.sv
module cfgseq_shift
   import cfgseq_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter int PHASE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              last_i,
   output logic              ready_o,
   output logic              cclk_o,
   output logic              cdata_o,
   output logic              fin_o
);

   localparam int PH_W  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   if (WORD_W < 1) begin : g_bad_word
      $error("cfgseq_shift: WORD_W must be at least 1");
   end
   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("cfgseq_shift: PHASE_CYC must be at least 1");
   end

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_next;
   logic [BIT_W-1:0]  bit_q;
   logic [PH_W-1:0]   ph_q;
   bit_step_e         step_q;
   logic [1:0]        step_inc;
   logic              active_q;
   logic              last_q;
   logic              fin_q;
   logic              step_end;
   logic              bit_end;
   logic              word_end;

   if (WORD_W == 1) begin : g_single
      assign word_next = word_q;
   end else begin : g_multi
      assign word_next = {word_q[WORD_W-2:0], 1'b0};
   end

   assign ready_o  = en_i && !active_q && !fin_q;
   assign step_end = active_q && (ph_q == PH_W'(PHASE_CYC - 1));
   assign bit_end  = step_end && (step_q == SP_RESTORE);
   assign word_end = bit_end && (bit_q == '0);
   assign step_inc = step_q + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         bit_q    <= '0;
         ph_q     <= '0;
         step_q   <= SP_CLK_LO;
         active_q <= 1'b0;
         last_q   <= 1'b0;
         fin_q    <= 1'b0;
      end else if (!en_i) begin
         active_q <= 1'b0;
         fin_q    <= 1'b0;
      end else if (ready_o && valid_i) begin
         word_q   <= data_i;
         bit_q    <= BIT_W'(WORD_W - 1);
         ph_q     <= '0;
         step_q   <= SP_CLK_LO;
         active_q <= 1'b1;
         last_q   <= last_i;
      end else if (active_q) begin
         if (step_end) begin
            ph_q   <= '0;
            step_q <= bit_step_e'(step_inc);
            if (word_end) begin
               active_q <= 1'b0;
               fin_q    <= last_q;
            end else if (bit_end) begin
               bit_q  <= bit_q - BIT_W'(1);
               word_q <= word_next;
            end
         end else begin
            ph_q <= ph_q + PH_W'(1);
         end
      end
   end

   assign cclk_o  = !active_q || (step_q == SP_CLK_HI) || (step_q == SP_RESTORE);
   assign cdata_o = !(active_q && ((step_q == SP_DATA) || (step_q == SP_CLK_HI)))
                    || word_q[WORD_W-1];
   assign fin_o   = fin_q;

endmodule

// File: rtl/cfgseq_loader.sv
module cfgseq_loader
   import cfgseq_pkg::*;
#(
   parameter int WORD_W        = 8,
   parameter int TICK_DIV      = 100000,
   parameter int POLL_LIMIT    = 4,
   parameter int PHASE_CYC     = 1,
   parameter int SYNC_STAGES   = 2,
   parameter bit PROG_ACT_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   input  logic              s_valid_i,
   output logic              s_ready_o,
   input  logic [WORD_W-1:0] s_data_i,
   input  logic              s_last_i,
   output logic              prog_o,
   output logic              cclk_o,
   output logic              cdata_o,
   input  logic              init_i,
   input  logic              done_i,
   output logic              res_valid_o,
   output logic [2:0]        res_code_o
);

   cfg_state_e state_q, state_d;
   res_code_t  code_q, code_d;
   logic       fire_d, fire_q;
   logic       init_s, done_s;
   logic       w_arm, w_cond, w_met, w_exp;
   logic       sh_en, sh_fin;
   logic       prog_act;

   cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
      .clk(clk), .rst_n(rst_n), .d_i(init_i), .q_o(init_s)
   );

   cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s)
   );

   always_comb begin
      w_arm  = 1'b0;
      w_cond = 1'b0;
      unique case (state_q)
         ST_PROG:  begin w_arm = 1'b1; w_cond = !init_s; end
         ST_REL:   begin w_arm = 1'b1; w_cond = init_s;  end
         ST_DONEW: begin w_arm = 1'b1; w_cond = done_s;  end
         default:  begin w_arm = 1'b0; w_cond = 1'b0;    end
      endcase
   end

   cfgseq_watch #(.TICK_DIV(TICK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm_i(w_arm), .cond_i(w_cond),
      .met_o(w_met), .expired_o(w_exp)
   );

   assign sh_en = (state_q == ST_SHIFT);

   cfgseq_shift #(.WORD_W(WORD_W), .PHASE_CYC(PHASE_CYC)) u_shift (
      .clk(clk), .rst_n(rst_n), .en_i(sh_en), .valid_i(s_valid_i),
      .data_i(s_data_i), .last_i(s_last_i), .ready_o(s_ready_o),
      .cclk_o(cclk_o), .cdata_o(cdata_o), .fin_o(sh_fin)
   );

   always_comb begin
      state_d = state_q;
      fire_d  = 1'b0;
      code_d  = RC_OK;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_PROG;
         ST_PROG:  begin
            if (w_met) state_d = ST_REL;
            else if (w_exp) begin
               state_d = ST_IDLE; fire_d = 1'b1; code_d = RC_INIT_LOW;
            end
         end
         ST_REL:   begin
            if (w_met) state_d = ST_SHIFT;
            else if (w_exp) begin
               state_d = ST_IDLE; fire_d = 1'b1; code_d = RC_INIT_HIGH;
            end
         end
         ST_SHIFT: if (sh_fin) state_d = ST_DONEW;
         ST_DONEW: begin
            if (w_met) begin
               state_d = ST_IDLE; fire_d = 1'b1; code_d = RC_OK;
            end else if (w_exp) begin
               state_d = ST_IDLE; fire_d = 1'b1; code_d = RC_DONE;
            end
         end
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fire_q  <= 1'b0;
         code_q  <= RC_OK;
      end else begin
         state_q <= state_d;
         fire_q  <= fire_d;
         if (fire_d) code_q <= code_d;
      end
   end

   assign prog_act = (state_q == ST_PROG);

   if (PROG_ACT_HIGH) begin : g_prog_high
      assign prog_o = prog_act;
   end else begin : g_prog_low
      assign prog_o = !prog_act;
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign res_valid_o = fire_q;
   assign res_code_o  = code_q;

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
   parameter bit PROG_ACT_HIGH = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       s_ready,
   input logic       prog,
   input logic       cclk,
   input logic       cdata,
   input logic       res_valid,
   input logic [2:0] res_code
);

   localparam logic PROG_IDLE = !PROG_ACT_HIGH;

   AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (prog == PROG_IDLE && cclk && cdata && !s_ready)); // R1

   AST_PROG_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (prog != PROG_IDLE) |-> busy); // R2

   AST_DATA_HIGH_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cclk) |-> cdata); // R4

   AST_DATA_SETTLED_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $stable(cdata)); // R4

   AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R7

   AST_RESULT_ENDS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy); // R7

   AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code == 3'b000 || res_code == 3'b111 ||
                     res_code == 3'b110 || res_code == 3'b101)); // R7

   AST_READY_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (busy && prog == PROG_IDLE)); // R8

endmodule

bind cfgseq_loader cfgseq_chk #(.PROG_ACT_HIGH(PROG_ACT_HIGH)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_o), .s_ready(s_ready_o),
   .prog(prog_o), .cclk(cclk_o), .cdata(cdata_o),
   .res_valid(res_valid_o), .res_code(res_code_o)
);

// File: tb/cfgseq_loader_tb_top.sv
`timescale 1ns/1ps
module cfgseq_loader_tb_top;

   localparam int WW    = 8;
   localparam int TDIV  = 8;
   localparam int PLIM  = 4;
   localparam int PCYC  = 2;
   localparam int NEVER = 1000000000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          busy_o;
   logic          s_valid_i = 1'b0;
   logic          s_ready_o;
   logic [WW-1:0] s_data_i = '0;
   logic          s_last_i = 1'b0;
   logic          prog_o, cclk_o, cdata_o;
   logic          init_i = 1'b1;
   logic          done_i = 1'b0;
   logic          res_valid_o;
   logic [2:0]    res_code_o;

   logic          start_h = 1'b0;
   logic          busy_h, ready_h, prog_h, cclk_h, cdata_h, resv_h;
   logic [2:0]    code_h;

   always #5 clk = ~clk;

   cfgseq_loader #(.WORD_W(WW), .TICK_DIV(TDIV), .POLL_LIMIT(PLIM),
                   .PHASE_CYC(PCYC), .SYNC_STAGES(2), .PROG_ACT_HIGH(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
      .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
      .s_last_i(s_last_i), .prog_o(prog_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
      .init_i(init_i), .done_i(done_i), .res_valid_o(res_valid_o),
      .res_code_o(res_code_o)
   );

   cfgseq_loader #(.WORD_W(WW), .TICK_DIV(TDIV), .POLL_LIMIT(PLIM),
                   .PHASE_CYC(PCYC), .SYNC_STAGES(2), .PROG_ACT_HIGH(1'b1)) dut_hi (
      .clk(clk), .rst_n(rst_n), .start_i(start_h), .busy_o(busy_h),
      .s_valid_i(1'b0), .s_ready_o(ready_h), .s_data_i('0),
      .s_last_i(1'b0), .prog_o(prog_h), .cclk_o(cclk_h), .cdata_o(cdata_h),
      .init_i(1'b1), .done_i(1'b0), .res_valid_o(resv_h),
      .res_code_o(code_h)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard: expected serial bits
   bit exp_q[$];

   // target model and monitor state
   int  fall_dly = 5, rise_dly = 5, done_dly = 5;
   bit  model_clr = 1'b0;
   int  tm = 0, tcnt = 0, dcnt = 0;
   int  bits_seen = 0, bits_total = 0;
   int  lo_cnt = 0;
   int  res_cnt = 0;
   logic cclk_prev = 1'b1;

   always @(negedge clk) begin
      if (model_clr) begin
         init_i = 1'b1; done_i = 1'b0; tm = 0; tcnt = 0; dcnt = 0;
         bits_seen = 0; model_clr = 1'b0;
      end else if (rst_n) begin
         case (tm)
            0: if (prog_o == 1'b0) begin tm = 1; tcnt = 0; end
            1: begin
               tcnt++;
               if (tcnt == fall_dly) init_i = 1'b0;
               if (prog_o == 1'b1) begin tm = 2; tcnt = 0; end
            end
            default: begin
               tcnt++;
               if (tcnt == rise_dly) init_i = 1'b1;
            end
         endcase
         if (bits_total > 0 && bits_seen == bits_total) begin
            dcnt++;
            if (dcnt == done_dly) done_i = 1'b1;
         end
      end
      // monitor
      if (rst_n) begin
         if (res_valid_o) res_cnt++;
         if (!cclk_prev && cclk_o) begin
            chk(lo_cnt == 2 * PCYC, "R4", "clock low width", lo_cnt, 2 * PCYC);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected clock rise, queue size", 0, 1);
            end else begin
               bit e;
               e = exp_q.pop_front();
               chk(cdata_o == e, "R5", "serial bit", cdata_o, e);
               bits_seen++;
            end
         end
         if (cclk_prev && !cclk_o)
            chk(cdata_o == 1'b1, "R4", "data at clock fall", cdata_o, 1);
         lo_cnt = cclk_o ? 0 : lo_cnt + 1;
         cclk_prev = cclk_o;
      end
   end

   logic [WW-1:0] w_arr [4];

   task automatic send_word(input logic [WW-1:0] w, input bit last);
      for (int b = WW - 1; b >= 0; b--) exp_q.push_back(w[b]);
      @(negedge clk);
      s_valid_i = 1'b1; s_data_i = w; s_last_i = last;
      while (!s_ready_o) @(negedge clk);
      @(negedge clk);
      s_valid_i = 1'b0; s_last_i = 1'b0;
   endtask

   task automatic check_idle(input string req);
      chk(prog_o == 1'b1 && cclk_o && cdata_o && !busy_o && !s_ready_o,
          req, "idle lines {prog,cclk,cdata,busy,ready}",
          {prog_o, cclk_o, cdata_o, busy_o, s_ready_o}, 5'b11100);
   endtask

   task automatic run_session(input string req, input int f, input int r,
                              input int d, input int nw, input logic [2:0] exp_code,
                              input bit junk, input bit restart_mid);
      int t;
      int rc0;
      fall_dly = f; rise_dly = r; done_dly = d;
      bits_total = nw * WW;
      model_clr = 1'b1;
      @(negedge clk); @(negedge clk);
      rc0 = res_cnt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (junk) begin
         s_valid_i = 1'b1; s_data_i = 8'h00; s_last_i = 1'b1;
      end
      for (int k = 0; k < nw; k++) begin
         send_word(w_arr[k], k == nw - 1);
         if (restart_mid && k == 0) begin
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
         end
      end
      t = 0;
      while (!res_valid_o && t < 5000) begin @(negedge clk); t++; end
      s_valid_i = 1'b0; s_last_i = 1'b0;
      chk(res_valid_o, req, "result strobe seen", res_valid_o, 1);
      chk(res_code_o == exp_code, req, "result code", res_code_o, exp_code);
      chk(exp_q.size() == 0, "R5", "bits left in scoreboard", exp_q.size(), 0);
      @(negedge clk);
      chk(!res_valid_o, "R7", "strobe lasts one cycle", res_valid_o, 0);
      check_idle("R1");
      repeat (60) @(negedge clk);
      chk(res_cnt - rc0 == 1, restart_mid ? "R9" : "R7", "results per session",
          res_cnt - rc0, 1);
      chk(!busy_o, restart_mid ? "R9" : "R1", "busy after session", busy_o, 0);
   endtask

   initial begin
      w_arr[0] = 8'hA5; w_arr[1] = 8'h3C; w_arr[2] = 8'hFF; w_arr[3] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      chk(!res_valid_o, "R1", "no result after reset", res_valid_o, 0);

      // normal session, four words
      run_session("R6", 5, 5, 5, 4, 3'b000, 1'b0, 1'b0);
      // init falls only in time for the last permitted poll
      run_session("R2", 33, 5, 5, 1, 3'b000, 1'b0, 1'b0);
      // init never falls; words offered meanwhile must not shift
      run_session("R2", NEVER, 5, 5, 0, 3'b111, 1'b1, 1'b0);
      // init never rises again; junk again must not shift (R8)
      run_session("R3", 5, NEVER, 5, 0, 3'b110, 1'b1, 1'b0);
      // done never rises
      w_arr[0] = 8'h80; w_arr[1] = 8'h7E;
      run_session("R6", 5, 5, NEVER, 2, 3'b101, 1'b0, 1'b0);
      // start pulse during shifting is ignored
      w_arr[0] = 8'h5A; w_arr[1] = 8'hC3; w_arr[2] = 8'h00;
      run_session("R9", 5, 5, 5, 3, 3'b000, 1'b0, 1'b1);

      // idle: offered word has no effect on the lines (R8)
      @(negedge clk);
      s_valid_i = 1'b1; s_data_i = 8'h00; s_last_i = 1'b1;
      begin
         bit ok = 1'b1;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (!(cclk_o && cdata_o && !s_ready_o && !busy_o)) ok = 1'b0;
         end
         chk(ok, "R8", "idle lines with word offered", ok, 1);
      end
      s_valid_i = 1'b0; s_last_i = 1'b0;

      // active-high program option
      chk(prog_h == 1'b0, "R10", "active-high strobe idle level", prog_h, 0);
      @(negedge clk); start_h = 1'b1;
      @(negedge clk); start_h = 1'b0;
      chk(prog_h == 1'b1, "R10", "active-high strobe asserted", prog_h, 1);
      begin
         int t = 0;
         while (!resv_h && t < 2000) begin @(negedge clk); t++; end
      end
      chk(code_h == 3'b111, "R10", "active-high session code", code_h, 3'b111);
      @(negedge clk);
      chk(prog_h == 1'b0 && !busy_h && cclk_h && cdata_h && !ready_h,
          "R10", "active-high strobe released", prog_h, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule